// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block recovers a card-to-reader reply of a length fixed in advance (1 to 32 bits) from the output of a level comparator. The reply has no start or stop marker, so the block is armed by a trigger that marks the end of the reader's outgoing frame. It then waits a fixed number of timing ticks and slices the comparator signal into equal, back-to-back bit windows. A bit is present when the comparator toggles often enough to show a subcarrier. An absent card therefore reads as all zeros.

When encryption is on, the block pulls keystream bits from an external generator before the first window opens. Each decoded bit is XORed with its own keystream bit. After the last window the block reports the word and its length, and it raises a pulse that realigns the shared response timer for the next exchange.

Top module: `scer_rx`

## Requirements
- R1: The first bit window opens exactly WAIT_TICKS (default 490) ticks after the trigger. With a tick in every cycle, `done_o` is high in the cycle that follows the rising edge WAIT_TICKS + WIN_TICKS·n cycles after the rising edge that samples `start_i`.
- R2: Each bit window lasts WIN_TICKS (default 150) ticks, and windows follow one another with no gap.
- R3: A bit decodes as 1 when the number of synchronised level changes counted in its window is greater than 20 and less than 60. Any other count decodes as 0.
- R4: The per-window edge counter saturates at 63, so 64 or more changes (for example 106) decode as 0 and never wrap back into the valid range.
- R5: The requested length is clamped to the range 1 to 32: a request above 32 gives 32 bits, and a request of 0 gives 1 bit. `bits_o` reports the length used.
- R6: Bit i of the reply is stored at `data_o[i]` (least significant bit first). Positions at or above the length read 0.
- R7: With `crypt_i` set at the trigger, `ks_adv_o` pulses exactly 2 + n times before reception. The keystream bit present with the k-th pulse (k counted from 0, k ≥ 2) is XORed into reply bit k − 2. With `crypt_i` clear, `ks_adv_o` never pulses.
- R8: `done_o` and `resync_o` are single-cycle pulses, both high in the same cycle, after the last window closes.
- R9: Timing advances only in cycles where `tick_i` is high. With ticks on alternate cycles, decoding is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Trigger marking the end of the reader frame; a trigger during reception restarts it |
| bit_count_i | input | 6 | Requested reply length in bits |
| crypt_i | input | 1 | Decrypt the reply with the keystream |
| tick_i | input | 1 | Timing tick enable |
| comp_i | input | 1 | Raw asynchronous comparator output |
| ks_bit_i | input | 1 | Current keystream bit |
| ks_adv_o | output | 1 | Advance strobe to the keystream generator |
| data_o | output | 32 | Received word, least significant bit first |
| bits_o | output | 6 | Length in bits of the received word |
| done_o | output | 1 | Reception complete pulse |
| resync_o | output | 1 | Response timer realignment pulse |

## Verification
The bench builds the block with its default parameters: a 490-tick wait, 150-tick windows and a 32-bit word. Back-to-back full-length frames sweep the injected toggle count per window from 0 to 130. This covers both decision thresholds and the region beyond 64, where a wrapping counter would return to the valid range. Further frames combine encryption with the length clamps at 0 and 40. One frame runs on ticks at half rate, and completion timing is checked to the cycle.

// File: rtl/scer_pkg.sv
package scer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RECV = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_PRE  = 2'd1,
        KS_CAP  = 2'd2
    } ks_state_e;

endpackage

// File: rtl/scer_sync.sv
module scer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic edge_o
);
    logic [STAGES:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/scer_edge_cnt.sv
module scer_edge_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                         cnt_d = inc_i ? CNT_W'(1) : '0;
        else if (inc_i && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // Saturation: a full counter stays full until cleared.
    assert_hold_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);

    // Each synchronised change below saturation adds exactly one.
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/scer_key_cap.sv
module scer_key_cap
    import scer_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int PRE_ADV  = 2,
    localparam int BITS_W  = $clog2(MAX_BITS + 1),
    localparam int IDX_W   = $clog2(MAX_BITS),
    localparam int PRE_W   = $clog2(PRE_ADV + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                crypt_i,
    input  logic [BITS_W-1:0]   nbits_i,
    input  logic                ks_bit_i,
    output logic                ks_adv_o,
    output logic [MAX_BITS-1:0] key_o
);
    typedef struct packed {
        ks_state_e           st;
        logic [PRE_W-1:0]    pre;
        logic [IDX_W-1:0]    idx;
        logic [BITS_W-1:0]   nbits;
        logic [MAX_BITS-1:0] key;
    } kc_t;

    kc_t q, d;

    always_comb begin
        d = q;
        if (start_i) begin
            d.key   = '0;
            d.pre   = '0;
            d.idx   = '0;
            d.nbits = nbits_i;
            d.st    = crypt_i ? KS_PRE : KS_IDLE;
        end else begin
            case (q.st)
                KS_PRE: begin
                    if (q.pre == PRE_W'(PRE_ADV - 1)) d.st  = KS_CAP;
                    else                              d.pre = q.pre + PRE_W'(1);
                end
                KS_CAP: begin
                    d.key[q.idx] = ks_bit_i;
                    if (BITS_W'(q.idx) == q.nbits - BITS_W'(1)) d.st  = KS_IDLE;
                    else                                        d.idx = q.idx + IDX_W'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= KS_IDLE;
            q.pre   <= '0;
            q.idx   <= '0;
            q.nbits <= '0;
            q.key   <= '0;
        end else begin
            q <= d;
        end
    end

    assign ks_adv_o = (q.st != KS_IDLE) && !start_i;
    assign key_o    = q.key;

    // The preamble always hands over to capture, never back to idle.
    assert_pre_then_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == KS_PRE && !start_i && q.pre == PRE_W'(PRE_ADV - 1)) |=> q.st == KS_CAP);
endmodule

// File: rtl/scer_rx.sv
module scer_rx
    import scer_pkg::*;
#(
    parameter int WAIT_TICKS  = 490,
    parameter int WIN_TICKS   = 150,
    parameter int EDGE_LO     = 20,
    parameter int EDGE_HI     = 60,
    parameter int CNT_W       = 6,
    parameter int MAX_BITS    = 32,
    parameter int PRE_ADV     = 2,
    parameter int SYNC_STAGES = 2,
    localparam int BITS_W     = $clog2(MAX_BITS + 1),
    localparam int IDX_W      = $clog2(MAX_BITS),
    localparam int TMAX       = (WAIT_TICKS > WIN_TICKS) ? WAIT_TICKS : WIN_TICKS,
    localparam int TCNT_W     = $clog2(TMAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [BITS_W-1:0]   bit_count_i,
    input  logic                crypt_i,
    input  logic                tick_i,
    input  logic                comp_i,
    input  logic                ks_bit_i,
    output logic                ks_adv_o,
    output logic [MAX_BITS-1:0] data_o,
    output logic [BITS_W-1:0]   bits_o,
    output logic                done_o,
    output logic                resync_o
);
    typedef struct packed {
        rx_state_e           st;
        logic [TCNT_W-1:0]   tcnt;
        logic [IDX_W-1:0]    bidx;
        logic [BITS_W-1:0]   nbits;
        logic [MAX_BITS-1:0] data;
        logic                crypt;
        logic                done;
        logic                resync;
    } rx_t;

    rx_t q, d;

    logic                edge_w;
    logic                clr_w;
    logic [CNT_W-1:0]    ecnt_w;
    logic [MAX_BITS-1:0] key_w;
    logic [BITS_W-1:0]   nbits_w;
    logic                present_w;

    always_comb begin
        if (bit_count_i == '0)                         nbits_w = BITS_W'(1);
        else if (bit_count_i > BITS_W'(MAX_BITS))      nbits_w = BITS_W'(MAX_BITS);
        else                                           nbits_w = bit_count_i;
    end

    scer_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (comp_i),
        .edge_o (edge_w)
    );

    scer_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_w),
        .inc_i (edge_w),
        .cnt_o (ecnt_w)
    );

    scer_key_cap #(.MAX_BITS(MAX_BITS), .PRE_ADV(PRE_ADV)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .crypt_i  (crypt_i),
        .nbits_i  (nbits_w),
        .ks_bit_i (ks_bit_i),
        .ks_adv_o (ks_adv_o),
        .key_o    (key_w)
    );

    assign present_w = (int'(ecnt_w) > EDGE_LO) && (int'(ecnt_w) < EDGE_HI);

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.resync = 1'b0;
        clr_w    = 1'b0;
        if (start_i) begin
            d.st    = ST_WAIT;
            d.tcnt  = '0;
            d.bidx  = '0;
            d.nbits = nbits_w;
            d.data  = '0;
            d.crypt = crypt_i;
        end else begin
            case (q.st)
                ST_WAIT: begin
                    if (tick_i) begin
                        if (q.tcnt == TCNT_W'(WAIT_TICKS - 1)) begin
                            d.st   = ST_RECV;
                            d.tcnt = '0;
                            clr_w  = 1'b1;
                        end else begin
                            d.tcnt = q.tcnt + TCNT_W'(1);
                        end
                    end
                end
                ST_RECV: begin
                    if (tick_i) begin
                        if (q.tcnt == TCNT_W'(WIN_TICKS - 1)) begin
                            d.tcnt         = '0;
                            clr_w          = 1'b1;
                            d.data[q.bidx] = present_w ^ (q.crypt & key_w[q.bidx]);
                            if (BITS_W'(q.bidx) == q.nbits - BITS_W'(1)) begin
                                d.st     = ST_IDLE;
                                d.done   = 1'b1;
                                d.resync = 1'b1;
                            end else begin
                                d.bidx = q.bidx + IDX_W'(1);
                            end
                        end else begin
                            d.tcnt = q.tcnt + TCNT_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.tcnt   <= '0;
            q.bidx   <= '0;
            q.nbits  <= '0;
            q.data   <= '0;
            q.crypt  <= 1'b0;
            q.done   <= 1'b0;
            q.resync <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign data_o   = q.data;
    assign bits_o   = q.nbits;
    assign done_o   = q.done;
    assign resync_o = q.resync;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    assert_done_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.nbits >= BITS_W'(1) && q.nbits <= BITS_W'(MAX_BITS)));

    assert_key_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RECV) |-> !ks_adv_o || start_i);

    assert_tick_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && !tick_i && !start_i) |=> $stable(q.tcnt));
endmodule

// File: tb/scer_rx_tb.sv
module scer_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  bit_count = '0;
    logic        crypt = 1'b0;
    logic        tick = 1'b1;
    logic        comp = 1'b0;
    logic        ks_bit;
    logic        ks_adv;
    logic [31:0] data;
    logic [5:0]  bits;
    logic        done;
    logic        resync;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ksi = 0;
    bit half_rate = 1'b0;

    always #2.5 clk = ~clk;

    scer_rx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .bit_count_i (bit_count),
        .crypt_i     (crypt),
        .tick_i      (tick),
        .comp_i      (comp),
        .ks_bit_i    (ks_bit),
        .ks_adv_o    (ks_adv),
        .data_o      (data),
        .bits_o      (bits),
        .done_o      (done),
        .resync_o    (resync)
    );

    function automatic bit ks_fn(int x);
        return ^(x & 32'h2D);
    endfunction

    assign ks_bit = ks_fn(ksi);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ks_adv) ksi <= ksi + 1;
    end

    always @(negedge clk) tick <= half_rate ? cyc[0] : 1'b1;

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int kval(int base, int i);
        return (base + i) % 131;
    endfunction

    task automatic run_frame(int req, bit cr, int period, int kbase, bit timing);
        int n;
        int s;
        int ks0;
        int dc;
        logic [31:0] exp;
        n = (req == 0) ? 1 : ((req > 32) ? 32 : req);
        exp = '0;
        @(negedge clk);
        ks0 = ksi;
        bit_count = 6'(req);
        crypt = cr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        s = cyc;
        for (int i = 0; i < n; i++) begin
            int k;
            k = kval(kbase, i);
            exp[i] = ((k > 20) && (k < 60)) ^ (cr & ks_fn(ks0 + 2 + i));
            while (cyc < s + period * (490 + 150 * i) + 10 * period) @(negedge clk);
            for (int j = 0; j < k; j++) begin
                comp = ~comp;
                @(negedge clk);
            end
        end
        while (!done && cyc < s + period * 6000) @(negedge clk);
        dc = cyc - s;
        check(done == 1'b1, "R8 done seen", done, 1);
        check(resync == 1'b1, "R8 resync with done", resync, 1);
        if (timing) check(dc == 490 + 150 * n, "R1 R2 completion cycle", dc, 490 + 150 * n);
        check(data == exp, (kbase >= 64) ? "R3 R4 R6 data" : "R3 R6 R7 data", data, exp);
        check(bits == 6'(n), "R5 length", bits, n);
        check(ksi - ks0 == (cr ? 2 + n : 0), "R7 keystream advances", ksi - ks0, cr ? 2 + n : 0);
        @(negedge clk);
        check(done == 1'b0 && resync == 1'b0, "R8 single pulse", {done, resync}, 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0 && resync == 1'b0 && ks_adv == 1'b0, "reset outputs", {done, resync, ks_adv}, 0);
        check(data == 32'h0 && bits == 6'h0, "reset word", data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R3, R4, R6: sweep 0..130 toggles per window
        for (int f = 0; f < 5; f++) run_frame(32, 1'b0, 1, f * 32, 1'b1);
        // R7: encrypted frames
        run_frame(32, 1'b1, 1, 7, 1'b1);
        run_frame(7, 1'b1, 1, 30, 1'b1);
        // R5: clamps
        run_frame(40, 1'b1, 1, 15, 1'b1);
        run_frame(0, 1'b0, 1, 42, 1'b1);
        run_frame(1, 1'b1, 1, 40, 1'b1);
        // R6: short frame leaves upper bits clear
        run_frame(12, 1'b0, 1, 18, 1'b1);
        // R9: half-rate ticks
        half_rate = 1'b1;
        run_frame(6, 1'b1, 2, 19, 1'b0);
        half_rate = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule